// File: doc/BRIEF.md
# Seven-to-one serial frame deserializer

This block sits behind four LVDS data receivers and one framing-clock receiver. All five lanes are sampled by a clock running at seven times the frame rate. That clock is supplied from outside with its phase already centred on the bits. The block finds where each frame starts from the framing lane, which is high for four bit times and low for three. It then shifts seven bits per lane into four small shift registers. At the end of every frame it rebuilds a 28-bit parallel word, in which each serial bit lands on a fixed, non-sequential output position.

The word is presented with a one-cycle strobe, once per frame. The block only delivers words once alignment has been confirmed over several consecutive frames; until then the word reads zero. An active-low shutdown input clears every register while it is low, and so stops the strobe. A synchronous active-high reset has the same clearing effect.

Top module: `lvds7_deser`

## Requirements
- R1: Once locked, every 7 sample clocks the block captures one 28-bit word from 7 consecutive samples of each of the 4 data lanes. It pulses `strobe_o` high for exactly one cycle per word, so strobes are exactly 7 cycles apart.
- R2: Lanes 0 and 1 are mapped as follows. Lane 0's samples, from earliest to latest, go to word bits 7, 6, 4, 3, 2, 1, 0. Lane 1's samples go to bits 18, 15, 14, 13, 12, 9, 8.
- R3: Lanes 2 and 3 are mapped as follows. Lane 2's samples, from earliest to latest, go to word bits 26, 25, 24, 22, 21, 20, 19. Lane 3's samples go to bits 23, 17, 16, 11, 10, 5, 27.
- R4: While unaligned, a frame starts at the first framing-lane sample that is 1 right after a 0 sample. The 7 samples from that one onward form the frame, and earlier samples never reach the word.
- R5: The framing lane of a valid frame reads 1,1,1,1,0,0,0 in time order. `locked_o` rises at the end of the 4th consecutive valid frame. That same edge also delivers the 4th frame's word and the first strobe.
- R6: A frame whose framing pattern differs from the valid pattern drops `locked_o` and clears the word at the end of that frame. Alignment is then searched for afresh, and 4 new valid frames are needed before the next strobe.
- R7: While `locked_o` is 0, `word_o` is 0 and `strobe_o` is 0.
- R8: At the first clock edge with `shdn_n` low, and at every edge while it stays low, all registers are cleared, so `word_o`, `strobe_o` and `locked_o` read 0.
- R9: After `shdn_n` returns high, no strobe appears until at least 2 complete valid frames have been received.
- R10: A synchronous high `rst` clears all state in the same way as shutdown.
- R11: Word, strobe and lock update at the clock edge that samples the 7th bit of a frame, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at seven times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Active-low shutdown/clear |
| frm_lane_i | input | 1 | Framing-clock lane sample |
| dat_lane_i | input | 4 | Data lane samples, bit n is lane n |
| word_o | output | 28 | Reassembled parallel word |
| strobe_o | output | 1 | One-cycle pulse per delivered word |
| locked_o | output | 1 | Frame alignment confirmed |

## Verification
The bench builds the block with its defaults: seven slots per lane, four high framing slots and a four-frame lock threshold. With these values, every lock or relock sequence is short enough to replay many times. A single walking bit can be sent through each of the 28 lane and slot positions to prove the bit map. The lock threshold is above the two-frame warm-up, so the bench can also show that no strobe appears in the frames following shutdown, a stray misaligned start, or a corrupted frame.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  localparam int LANES  = 4;
  localparam int SLOTS  = 7;
  localparam int WORD   = LANES * SLOTS;
  localparam int POS_W  = 5;

  // per-lane output positions, earliest sample in the most significant field
  localparam logic [SLOTS*POS_W-1:0] POS_L0 = {5'd7,  5'd6,  5'd4,  5'd3,  5'd2,  5'd1,  5'd0};
  localparam logic [SLOTS*POS_W-1:0] POS_L1 = {5'd18, 5'd15, 5'd14, 5'd13, 5'd12, 5'd9,  5'd8};
  localparam logic [SLOTS*POS_W-1:0] POS_L2 = {5'd26, 5'd25, 5'd24, 5'd22, 5'd21, 5'd20, 5'd19};
  localparam logic [SLOTS*POS_W-1:0] POS_L3 = {5'd23, 5'd17, 5'd16, 5'd11, 5'd10, 5'd5,  5'd27};

  function automatic int out_pos(int lane, int slot);
    logic [SLOTS*POS_W-1:0] row;
    case (lane)
      0:       row = POS_L0;
      1:       row = POS_L1;
      2:       row = POS_L2;
      default: row = POS_L3;
    endcase
    return int'(row[(SLOTS-1-slot)*POS_W +: POS_W]);
  endfunction
endpackage

// File: rtl/lvds7_lane_shift.sv
module lvds7_lane_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             din,
  output logic [SLOTS-1:0] frame
);
  logic [SLOTS-2:0] hist;

  always_ff @(posedge clk) begin
    if (clr) hist <= '0;
    else     hist <= {hist[SLOTS-3:0], din};
  end

  // current sample appended: bit SLOTS-1 is the earliest of the window
  assign frame = {hist, din};
endmodule

// File: rtl/lvds7_align.sv
module lvds7_align #(
  parameter int SLOTS       = 7,
  parameter int HIGH_SLOTS  = 4,
  parameter int LOCK_FRAMES = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [SLOTS-1:0] pat,
  output logic             capture,
  output logic             drop,
  output logic             locked
);
  localparam int NEED = (LOCK_FRAMES < 2) ? 2 : LOCK_FRAMES;
  localparam int CW   = $clog2(SLOTS);
  localparam int GW   = $clog2(NEED + 1);
  localparam logic [SLOTS-1:0] ONES = SLOTS'((1 << HIGH_SLOTS) - 1);
  localparam logic [SLOTS-1:0] GOOD = ONES << (SLOTS - HIGH_SLOTS);

  logic          aligned;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;
  logic          frame_end, pat_ok, lock_next, edge_seen;

  assign edge_seen = pat[0] && !pat[1];
  assign frame_end = aligned && (cnt == CW'(SLOTS - 1));
  assign pat_ok    = (pat == GOOD);
  assign lock_next = (good >= GW'(NEED - 1));
  assign capture   = frame_end && pat_ok && lock_next;
  assign drop      = frame_end && !pat_ok;

  always_ff @(posedge clk) begin
    if (clr) begin
      aligned <= 1'b0;
      cnt     <= '0;
      good    <= '0;
      locked  <= 1'b0;
    end else if (!aligned) begin
      if (edge_seen) begin
        aligned <= 1'b1;
        cnt     <= CW'(1);
      end
    end else if (frame_end) begin
      cnt <= '0;
      if (pat_ok) begin
        good   <= lock_next ? GW'(NEED) : good + GW'(1);
        locked <= lock_next;
      end else begin
        aligned <= 1'b0;
        good    <= '0;
        locked  <= 1'b0;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lvds7_out.sv
module lvds7_out #(
  parameter int LANES = 4,
  parameter int SLOTS = 7,
  parameter int WORD  = LANES * SLOTS
) (
  input  logic                   clk,
  input  logic                   clr,
  input  logic [LANES*SLOTS-1:0] frames,
  input  logic                   capture,
  input  logic                   drop,
  output logic [WORD-1:0]        word_o,
  output logic                   strobe_o
);
  import lvds7_pkg::*;

  logic [WORD-1:0] mapped;

  always_comb begin
    mapped = '0;
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < SLOTS; s++)
        mapped[out_pos(l, s)] = frames[l*SLOTS + SLOTS-1-s];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      word_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= capture;
      if (capture)   word_o <= mapped;
      else if (drop) word_o <= '0;
    end
  end
endmodule

// File: rtl/lvds7_deser.sv
module lvds7_deser #(
  parameter int HIGH_SLOTS  = 4,
  parameter int LOCK_FRAMES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        shdn_n,
  input  logic        frm_lane_i,
  input  logic [3:0]  dat_lane_i,
  output logic [27:0] word_o,
  output logic        strobe_o,
  output logic        locked_o
);
  localparam int LANES = lvds7_pkg::LANES;
  localparam int SLOTS = lvds7_pkg::SLOTS;
  localparam int WORD  = lvds7_pkg::WORD;

  logic                   clr;
  logic [LANES*SLOTS-1:0] frames;
  logic [SLOTS-1:0]       pat;
  logic                   capture, drop;

  assign clr = rst || !shdn_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvds7_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk(clk), .clr(clr), .din(dat_lane_i[l]),
      .frame(frames[l*SLOTS +: SLOTS])
    );
  end

  lvds7_lane_shift #(.SLOTS(SLOTS)) u_frm_shift (
    .clk(clk), .clr(clr), .din(frm_lane_i), .frame(pat)
  );

  lvds7_align #(.SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk(clk), .clr(clr), .pat(pat),
    .capture(capture), .drop(drop), .locked(locked_o)
  );

  lvds7_out #(.LANES(LANES), .SLOTS(SLOTS), .WORD(WORD)) u_out (
    .clk(clk), .clr(clr), .frames(frames), .capture(capture), .drop(drop),
    .word_o(word_o), .strobe_o(strobe_o)
  );
endmodule

// File: rtl/lvds7_deser_chk.sv
module lvds7_deser_chk #(
  parameter int SLOTS = 7,
  parameter int WORD  = 28
) (
  input logic            clk,
  input logic            rst,
  input logic            shdn_n,
  input logic [WORD-1:0] word_o,
  input logic            strobe_o,
  input logic            locked_o
);
  localparam int GAPW  = $clog2(SLOTS) + 2;
  localparam int WARM  = 2 * SLOTS;
  localparam int WARMW = $clog2(WARM + 1) + 1;

  logic [GAPW-1:0]  gap;
  logic             armed;
  logic [WARMW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst || !shdn_n) begin
      gap   <= '0;
      armed <= 1'b0;
      since <= '0;
    end else begin
      if (since < WARMW'(WARM)) since <= since + WARMW'(1);
      if (strobe_o) begin
        armed <= 1'b1;
        gap   <= '0;
      end else if (!locked_o) begin
        armed <= 1'b0;
      end else begin
        gap <= gap + GAPW'(1);
      end
    end
  end

  p_frame_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && armed) |-> (gap == GAPW'(SLOTS - 1)));

  p_lock_rise_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> strobe_o);

  p_word_zero_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
    !locked_o |-> (word_o == '0));

  p_strobe_locked_r7: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> locked_o);

  p_shdn_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (!strobe_o && !locked_o && word_o == '0));

  p_warm_frames_r9: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (since >= WARMW'(WARM)));
endmodule

bind lvds7_deser lvds7_deser_chk #(.SLOTS(SLOTS), .WORD(WORD)) u_chk (
  .clk(clk), .rst(rst), .shdn_n(shdn_n),
  .word_o(word_o), .strobe_o(strobe_o), .locked_o(locked_o)
);

// File: tb/sim_lvds7_deser.sv
`timescale 1ns/1ps
module sim_lvds7_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shdn_n = 1'b1;
  logic        frm_lane_i = 1'b0;
  logic [3:0]  dat_lane_i = '0;
  logic [27:0] word_o;
  logic        strobe_o, locked_o;

  int total = 0;
  int bad = 0;
  int stray;

  localparam logic [6:0] GOODP = 7'b1111000;
  int bmap [4][7] = '{'{7, 6, 4, 3, 2, 1, 0},
                      '{18, 15, 14, 13, 12, 9, 8},
                      '{26, 25, 24, 22, 21, 20, 19},
                      '{23, 17, 16, 11, 10, 5, 27}};

  lvds7_deser u0 (.clk(clk), .rst(rst), .shdn_n(shdn_n), .frm_lane_i(frm_lane_i),
                  .dat_lane_i(dat_lane_i), .word_o(word_o), .strobe_o(strobe_o),
                  .locked_o(locked_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic c, input logic [3:0] d);
    @(negedge clk);
    frm_lane_i = c;
    dat_lane_i = d;
  endtask

  // drives one frame, returns after the edge sampling its 7th bit (+1 ns)
  task automatic frame(input logic [27:0] w, input logic [6:0] cp);
    stray = 0;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      if (s > 0 && strobe_o) stray++;
      frm_lane_i = cp[6-s];
      for (int l = 0; l < 4; l++) dat_lane_i[l] = w[bmap[l][s]];
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 4'b1011);
  endtask

  task automatic expect_out(input string req, input logic st, input logic lk, input logic [27:0] w);
    chk({req, " strobe"}, 32'(strobe_o), 32'(st));
    chk({req, " locked"}, 32'(locked_o), 32'(lk));
    chk({req, " word"}, 32'(word_o), 32'(w));
  endtask

  // 3 quiet frames then the 4th delivers w
  task automatic lock_up(input string req, input logic [27:0] w);
    for (int f = 0; f < 3; f++) begin
      frame(28'h5A5A5A5 ^ 28'(f), GOODP);
      expect_out(req, 1'b0, 1'b0, 28'h0);
    end
    frame(w, GOODP);
    expect_out(req, 1'b1, 1'b1, w);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R10 reset", 1'b0, 1'b0, 28'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_lock;
    idle(3);
    lock_up("R5 lock", 28'hABCDEF1);
    frame(28'h1234567, GOODP);
    expect_out("R11 next frame", 1'b1, 1'b1, 28'h1234567);
    chk("R1 single pulse", 32'(stray), 32'd0);
  endtask

  task automatic t_map;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 7; s++) begin
        frame(28'(1) << bmap[l][s], GOODP);
        chk((l < 2) ? "R2 lane map" : "R3 lane map", 32'(word_o), 32'(28'(1) << bmap[l][s]));
      end
    frame(28'hFFFFFFF, GOODP);
    chk("R1 all ones", 32'(word_o), 32'h0FFFFFFF);
    frame(28'h0F0C3A5, GOODP);
    chk("R1 mixed", 32'(word_o), 32'h00F0C3A5);
    chk("R1 gap", 32'(stray), 32'd0);
  endtask

  task automatic t_mismatch;
    frame(28'h7777777, 7'b1110000);
    expect_out("R6 drop", 1'b0, 1'b0, 28'h0);
    lock_up("R6 relock", 28'h2468ACE);
    frame(28'h1357BDF, 7'b1111100);
    expect_out("R6 drop2", 1'b0, 1'b0, 28'h0);
  endtask

  task automatic t_align;
    // stray start: two high samples, two low, then real frames
    put(1'b1, 4'hF); put(1'b1, 4'hF); put(1'b0, 4'hF); put(1'b0, 4'hF);
    frame(28'hEEEEEEE, GOODP);
    expect_out("R4 stray", 1'b0, 1'b0, 28'h0);
    lock_up("R4 realign", 28'h0C0FFEE);
  endtask

  task automatic t_shutdown;
    put(1'b1, 4'h3); put(1'b1, 4'h3);
    @(negedge clk);
    shdn_n = 1'b0;
    frm_lane_i = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R8 clear", 1'b0, 1'b0, 28'h0);
    idle(2);
    frame(28'h1111111, GOODP);
    expect_out("R8 held", 1'b0, 1'b0, 28'h0);
    frame(28'h2222222, GOODP);
    expect_out("R8 held", 1'b0, 1'b0, 28'h0);
    @(negedge clk);
    shdn_n = 1'b1;
    frm_lane_i = 1'b0;
    for (int f = 0; f < 2; f++) begin
      frame(28'h3333333, GOODP);
      expect_out("R9 warmup", 1'b0, 1'b0, 28'h0);
    end
    frame(28'h4444444, GOODP);
    chk("R9 warmup strobe", 32'(strobe_o), 32'd0);
    frame(28'h9876543, GOODP);
    expect_out("R9 resume", 1'b1, 1'b1, 28'h9876543);
  endtask

  task automatic t_rst_mid;
    @(negedge clk);
    rst = 1'b1;
    frm_lane_i = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R10 mid reset", 1'b0, 1'b0, 28'h0);
    @(negedge clk);
    rst = 1'b0;
    frm_lane_i = 1'b0;
    idle(1);
    lock_up("R10 after reset", 28'h8000001);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_map();
    t_mismatch();
    t_align();
    t_shutdown();
    t_rst_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule